// File: doc/BRIEF.md
# Retriggerable Dual-Compare One-Shot Timer

This block produces one output pulse per trigger. A 16-bit up-counter is cleared to zero by a trigger and then advances once per count-enable tick. Two programmable compare values set the pulse edges: whichever is smaller marks the point where the pulse goes high, and the larger marks where it goes low. Each compare value also has its own single-cycle interrupt strobe. The strobe fires whenever the counter steps onto that value.

A run can be started in two ways. Software can set a self-clearing trigger bit through a small write port. Alternatively, a selected edge on an asynchronous trigger pin starts the run after that pin passes a two-flop synchronizer. A trigger that arrives while a pulse is in progress restarts the count, so a complete new pulse follows. After the pulse ends, the counter keeps running and wraps around. The output stays low until the next trigger.

Top module: `oneshot_timer`

## Requirements
- R1: While reset is held, and after its release with no register written, `pulse_o`, `irq_a_o` and `irq_b_o` are low. All registers reset to zero.
- R2: The write port uses three addresses.
  - Address 0 is control: bits [1:0] are the run mode, bits [3:2] select the trigger edge, and bit 4 is the software trigger.
  - Address 1 holds compare A.
  - Address 2 holds compare B.
  - When the run mode is 00, the counter is held at zero and triggers are ignored. No pulse or strobe occurs. Any nonzero mode lets the counter run.
- R3: Writing control with bit 4 set starts exactly one run. The counter is cleared on the clock edge after the write edge. The bit clears itself, so a single write never starts a second run.
- R4: The edge-select encoding is 00 none, 01 rising, 10 falling, 11 both. Edges that are not selected start nothing. A selected edge on `trig_i` clears the counter on the third rising clock edge after the pin changes.
- R5: When A < B, and the counter is cleared at edge t0 with a tick on every cycle, `pulse_o` rises at edge t0+A and falls at edge t0+B.
- R6: When A > B, the roles swap: `pulse_o` rises at t0+B and falls at t0+A.
- R7: When A == B, no pulse is produced, but both strobes fire together when the count reaches that value.
- R8: `irq_a_o` is high for one cycle, registered at the same edge that the counter steps onto A. `irq_b_o` behaves the same way for B.
- R9: A trigger during an active pulse drives `pulse_o` low at the clearing edge t1 (when the start value is nonzero). A full new pulse then follows, referenced to t1.
- R10: After the pulse ends, the counter wraps from FFFFh to 0000h and keeps counting. The strobes fire again on the matches after the wrap, but `pulse_o` stays low until a new trigger.
- R11: The counter advances only on cycles with `cnt_en_i` high. With a tick on every other cycle, the pulse lasts 2*(B-A) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Count-clock enable tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 compare A, 2 compare B) |
| wr_data_i | input | 16 | Register write data |
| trig_i | input | 1 | Asynchronous external trigger pin |
| pulse_o | output | 1 | One-shot pulse output |
| irq_a_o | output | 1 | Single-cycle strobe on a compare A match |
| irq_b_o | output | 1 | Single-cycle strobe on a compare B match |

## Verification
The assertions check four behaviours on every cycle:
- While the mode is zero, the counter sits at zero and the outputs are quiet.
- A trigger in a nonzero mode clears the counter on the next edge.
- The counter holds without a tick and increments by exactly one with a tick.
- Every rising edge of the pulse lands on the start compare value.

The directed scenarios cover behaviour that depends on a sequence of events:
- the exact edge-to-edge timing of the pulse in both compare orders;
- the equal-compare case that produces no pulse;
- edge selection through the synchronizer;
- a restart in the middle of a pulse;
- the long run through the counter wrap.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP_B = 2'd2;

  // control word layout
  localparam int unsigned CTRL_MODE_LSB = 0;
  localparam int unsigned CTRL_EDGE_LSB = 2;
  localparam int unsigned CTRL_SW_BIT   = 4;
  localparam int unsigned CTRL_MIN_W    = CTRL_SW_BIT + 1;

endpackage

// File: rtl/oneshot_regs.sv
module oneshot_regs
  import oneshot_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  output logic [1:0]        mode_o,
  output edge_sel_e         edge_sel_o,
  output logic [CW-1:0]     cmp_a_o,
  output logic [CW-1:0]     cmp_b_o,
  output logic              sw_trig_o
);

  logic ctrl_wr, cmp_a_wr, cmp_b_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign cmp_a_wr = wr_en_i && (wr_addr_i == ADDR_CMP_A);
  assign cmp_b_wr = wr_en_i && (wr_addr_i == ADDR_CMP_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= 2'b00;
      edge_sel_o <= EDGE_NONE;
      cmp_a_o    <= '0;
      cmp_b_o    <= '0;
      sw_trig_o  <= 1'b0;
    end else begin
      // self-clearing: high only for the cycle after a control write
      sw_trig_o <= ctrl_wr && wr_data_i[CTRL_SW_BIT];
      if (ctrl_wr) begin
        mode_o     <= wr_data_i[CTRL_MODE_LSB +: 2];
        edge_sel_o <= edge_sel_e'(wr_data_i[CTRL_EDGE_LSB +: 2]);
      end
      if (cmp_a_wr) cmp_a_o <= wr_data_i;
      if (cmp_b_wr) cmp_b_o <= wr_data_i;
    end
  end

endmodule

// File: rtl/oneshot_trig_detect.sv
module oneshot_trig_detect
  import oneshot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trig_i,
  input  edge_sel_e edge_sel_i,
  output logic      edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   synced, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= trig_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= synced;
  end

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: edge_o = rise;
      EDGE_FALL: edge_o = fall;
      EDGE_BOTH: edge_o = rise | fall;
      default:   edge_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          restart_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          step_o
);

  assign step_o    = restart_i | (run_i & tick_i);
  assign cnt_nxt_o = restart_i ? '0 : count_o + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (!run_i) count_o <= '0;
    else if (step_o) count_o <= cnt_nxt_o;
  end

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic          restart_i,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic [CW-1:0] cmp_a_i,
  input  logic [CW-1:0] cmp_b_i,
  output logic [CW-1:0] start_o,
  output logic          pulse_o,
  output logic          irq_a_o,
  output logic          irq_b_o
);

  logic          a_is_low, degen;
  logic [CW-1:0] stop_w;
  logic          hit_a, hit_b;
  logic          armed_q, armed_d, pulse_d;

  assign a_is_low = cmp_a_i < cmp_b_i;
  assign degen    = cmp_a_i == cmp_b_i;
  assign start_o  = a_is_low ? cmp_a_i : cmp_b_i;
  assign stop_w   = a_is_low ? cmp_b_i : cmp_a_i;

  assign hit_a = step_i && (cnt_nxt_i == cmp_a_i);
  assign hit_b = step_i && (cnt_nxt_i == cmp_b_i);

  always_comb begin
    pulse_d = restart_i ? 1'b0 : pulse_o;
    armed_d = restart_i | armed_q;
    if (step_i && armed_d && !degen && (cnt_nxt_i == start_o)) pulse_d = 1'b1;
    if (step_i && (cnt_nxt_i == stop_w)) begin
      pulse_d = 1'b0;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pulse_o <= 1'b0;
      irq_a_o <= 1'b0;
      irq_b_o <= 1'b0;
    end else if (!run_i) begin
      armed_q <= 1'b0;
      pulse_o <= 1'b0;
      irq_a_o <= 1'b0;
      irq_b_o <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_o <= pulse_d;
      irq_a_o <= hit_a;
      irq_b_o <= hit_b;
    end
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  input  logic              trig_i,
  output logic              pulse_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);

  logic [1:0]    mode_q;
  edge_sel_e     edge_sel;
  logic [CW-1:0] cmp_a, cmp_b;
  logic          sw_trig, ext_edge, trig, run, restart, step;
  logic [CW-1:0] count_q, cnt_nxt, start_val;

  oneshot_regs #(.CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_q),
    .edge_sel_o(edge_sel),
    .cmp_a_o   (cmp_a),
    .cmp_b_o   (cmp_b),
    .sw_trig_o (sw_trig)
  );

  oneshot_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .edge_sel_i(edge_sel),
    .edge_o    (ext_edge)
  );

  assign trig    = sw_trig | ext_edge;
  assign run     = mode_q != 2'b00;
  assign restart = run & trig;

  oneshot_counter #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .tick_i   (cnt_en_i),
    .restart_i(restart),
    .count_o  (count_q),
    .cnt_nxt_o(cnt_nxt),
    .step_o   (step)
  );

  oneshot_pulse_gen #(.CW(CW)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .step_i   (step),
    .restart_i(restart),
    .cnt_nxt_i(cnt_nxt),
    .cmp_a_i  (cmp_a),
    .cmp_b_i  (cmp_b),
    .start_o  (start_val),
    .pulse_o  (pulse_o),
    .irq_a_o  (irq_a_o),
    .irq_b_o  (irq_b_o)
  );

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnt_en_i,
  input logic          run,
  input logic          trig,
  input logic [CW-1:0] count_q,
  input logic [CW-1:0] start_val,
  input logic          pulse_o,
  input logic          irq_a_o,
  input logic          irq_b_o
);

  a_r2_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (!pulse_o && !irq_a_o && !irq_b_o));

  a_r2_stopped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (count_q == '0));

  a_r4_trig_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && trig) |=> (count_q == '0));

  a_r11_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !trig && !cnt_en_i) |=> $stable(count_q));

  a_r11_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !trig && cnt_en_i) |=> (count_q == CW'($past(count_q) + 1'b1)));

  a_r5_rise_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> (count_q == $past(start_val)));

endmodule

bind oneshot_timer oneshot_timer_chk #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .run      (run),
  .trig     (trig),
  .count_q  (count_q),
  .start_val(start_val),
  .pulse_o  (pulse_o),
  .irq_a_o  (irq_a_o),
  .irq_b_o  (irq_b_o)
);

// File: tb/tb_oneshot_timer.sv
`timescale 1ns/1ps
module tb_oneshot_timer;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [15:0] wr_data_i = 16'd0;
  logic        trig_i = 1'b0;
  logic        pulse_o, irq_a_o, irq_b_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int en_div = 1;
  bit done   = 1'b0;

  int rise_cnt = 0, fall_cnt = 0, a_cnt = 0, b_cnt = 0;
  int rise_cyc = -1, fall_cyc = -1, a_cyc = -1, b_cyc = -1;
  logic pulse_prev = 1'b0;

  oneshot_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .trig_i(trig_i), .pulse_o(pulse_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    cnt_en_i = (en_div == 1) ? 1'b1 : ((cyc % 2) == 0);
    if (pulse_o && !pulse_prev) begin rise_cnt++; rise_cyc = cyc; end
    if (!pulse_o && pulse_prev) begin fall_cnt++; fall_cyc = cyc; end
    if (irq_a_o) begin a_cnt++; a_cyc = cyc; end
    if (irq_b_o) begin b_cnt++; b_cyc = cyc; end
    pulse_prev = pulse_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl(input logic [1:0] mode,
                                       input logic [1:0] sel, input logic sw);
    return {11'd0, sw, sel, mode};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int w);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    w = cyc;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cfg(input int a, input int b, input logic [1:0] mode,
                     input logic [1:0] sel);
    int w;
    wr(2'd1, 16'(a), w);
    wr(2'd2, 16'(b), w);
    wr(2'd0, ctrl(mode, sel, 1'b0), w);
  endtask

  task automatic sw_fire(input logic [1:0] mode, input logic [1:0] sel,
                         output int t0);
    int w;
    wr(2'd0, ctrl(mode, sel, 1'b1), w);
    t0 = w + 1;
  endtask

  task automatic pin_set(input logic v, output int t0);
    @(negedge clk_i);
    trig_i = v;
    @(posedge clk_i); #1;
    t0 = cyc + 2;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(posedge clk_i);
    @(negedge clk_i); #1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk(pulse_o == 1'b0, "R1", "pulse in reset", pulse_o, 0);
    chk(irq_a_o == 1'b0 && irq_b_o == 1'b0, "R1", "irqs in reset",
        {irq_a_o, irq_b_o}, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(rise_cnt == 0, "R1", "no pulse after reset", rise_cnt, 0);
    chk(a_cnt + b_cnt == 0, "R1", "no strobe after reset", a_cnt + b_cnt, 0);
  endtask

  task automatic t_mode_off;
    int t0, tx, br, ba, bb;
    cfg(3, 8, 2'b00, 2'b11);
    br = rise_cnt; ba = a_cnt; bb = b_cnt;
    sw_fire(2'b00, 2'b11, t0);
    pin_set(1'b1, tx);
    pin_set(1'b0, tx);
    wait_to(tx + 40);
    chk(rise_cnt == br, "R2", "mode 00 pulses", rise_cnt - br, 0);
    chk(a_cnt == ba && b_cnt == bb, "R2", "mode 00 strobes",
        (a_cnt - ba) + (b_cnt - bb), 0);
  endtask

  task automatic t_basic;
    int t0, br;
    cfg(5, 12, 2'b01, 2'b00);
    br = rise_cnt;
    sw_fire(2'b01, 2'b00, t0);
    wait_to(t0 + 60);
    chk(rise_cyc == t0 + 5, "R5", "rise edge", rise_cyc, t0 + 5);
    chk(fall_cyc == t0 + 12, "R5", "fall edge", fall_cyc, t0 + 12);
    chk(a_cyc == t0 + 5, "R8", "irq_a edge", a_cyc, t0 + 5);
    chk(b_cyc == t0 + 12, "R8", "irq_b edge", b_cyc, t0 + 12);
    chk(rise_cnt - br == 1, "R3", "single run per sw write", rise_cnt - br, 1);
    chk(irq_a_o == 1'b0 && pulse_o == 1'b0, "R8", "strobe/pulse idle",
        {irq_a_o, pulse_o}, 0);
  endtask

  task automatic t_swap;
    int t0;
    cfg(20, 7, 2'b10, 2'b00);
    sw_fire(2'b10, 2'b00, t0);
    wait_to(t0 + 30);
    chk(rise_cyc == t0 + 7, "R6", "rise on B", rise_cyc, t0 + 7);
    chk(fall_cyc == t0 + 20, "R6", "fall on A", fall_cyc, t0 + 20);
    chk(b_cyc == t0 + 7, "R8", "irq_b at B", b_cyc, t0 + 7);
  endtask

  task automatic t_equal;
    int t0, br;
    cfg(9, 9, 2'b01, 2'b00);
    br = rise_cnt;
    sw_fire(2'b01, 2'b00, t0);
    wait_to(t0 + 30);
    chk(rise_cnt == br, "R7", "no pulse on equal", rise_cnt - br, 0);
    chk(a_cyc == t0 + 9, "R7", "irq_a on equal", a_cyc, t0 + 9);
    chk(b_cyc == t0 + 9, "R7", "irq_b on equal", b_cyc, t0 + 9);
  endtask

  task automatic t_retrig;
    int t0, t1, br, bf;
    cfg(4, 30, 2'b01, 2'b00);
    br = rise_cnt; bf = fall_cnt;
    sw_fire(2'b01, 2'b00, t0);
    wait_to(t0 + 10);
    chk(pulse_o == 1'b1, "R9", "pulse active before retrigger", pulse_o, 1);
    sw_fire(2'b01, 2'b00, t1);
    wait_to(t1);
    chk(pulse_o == 1'b0, "R9", "pulse low at restart", pulse_o, 0);
    wait_to(t1 + 40);
    chk(rise_cyc == t1 + 4, "R9", "new rise", rise_cyc, t1 + 4);
    chk(fall_cyc == t1 + 30, "R9", "new fall", fall_cyc, t1 + 30);
    chk(rise_cnt - br == 2, "R9", "two rises", rise_cnt - br, 2);
    chk(fall_cnt - bf == 2, "R9", "two falls", fall_cnt - bf, 2);
  endtask

  task automatic ext_expect(input logic v, input bit fire, input string what);
    int t0, br;
    br = rise_cnt;
    pin_set(v, t0);
    wait_to(t0 + 15);
    if (fire) begin
      chk(rise_cyc == t0 + 3, "R4", what, rise_cyc, t0 + 3);
      chk(fall_cyc == t0 + 10, "R4", what, fall_cyc, t0 + 10);
    end else begin
      chk(rise_cnt == br, "R4", what, rise_cnt - br, 0);
    end
  endtask

  task automatic t_ext;
    int w;
    cfg(3, 10, 2'b01, 2'b01);
    ext_expect(1'b1, 1'b1, "rising selected");
    ext_expect(1'b0, 1'b0, "falling ignored under rising");
    wr(2'd0, ctrl(2'b01, 2'b10, 1'b0), w);
    ext_expect(1'b1, 1'b0, "rising ignored under falling");
    ext_expect(1'b0, 1'b1, "falling selected");
    wr(2'd0, ctrl(2'b01, 2'b11, 1'b0), w);
    ext_expect(1'b1, 1'b1, "both: rising");
    ext_expect(1'b0, 1'b1, "both: falling");
    wr(2'd0, ctrl(2'b01, 2'b00, 1'b0), w);
    ext_expect(1'b1, 1'b0, "none: rising");
    ext_expect(1'b0, 1'b0, "none: falling");
  endtask

  task automatic t_tick;
    int t0, br;
    en_div = 2;
    cfg(3, 8, 2'b01, 2'b00);
    br = rise_cnt;
    sw_fire(2'b01, 2'b00, t0);
    wait_to(t0 + 40);
    chk(rise_cnt - br == 1, "R11", "one pulse at half rate", rise_cnt - br, 1);
    chk(fall_cyc - rise_cyc == 10, "R11", "width at half rate",
        fall_cyc - rise_cyc, 10);
    en_div = 1;
  endtask

  task automatic t_wrap;
    int t0, br;
    cfg(2, 6, 2'b01, 2'b00);
    br = rise_cnt;
    sw_fire(2'b01, 2'b00, t0);
    wait_to(t0 + 65536 + 12);
    chk(rise_cnt - br == 1, "R10", "no pulse after wrap", rise_cnt - br, 1);
    chk(a_cyc == t0 + 65538, "R10", "irq_a after wrap", a_cyc, t0 + 65538);
    chk(b_cyc == t0 + 65542, "R10", "irq_b after wrap", b_cyc, t0 + 65542);
    chk(pulse_o == 1'b0, "R10", "pulse low after wrap", pulse_o, 0);
  endtask

  initial begin
    t_reset();
    t_mode_off();
    t_basic();
    t_swap();
    t_equal();
    t_retrig();
    t_ext();
    t_tick();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule